// File: doc/BRIEF.md
# Free-Running Timer Counter with Split Test Mode

The block is a 16-bit free-running counter that advances on enable pulses from a power-of-two clock prescaler. When the count wraps from its largest value to zero, a sticky overflow flag is raised. Software clears the flag by writing a one to it. A separate compare-match input can force the count back to zero. The prescale ratio and the mode are held in a small configuration register, which is loaded by a write strobe.

A test mode exists for production testing. It skips the prescaler and splits the counter into two 8-bit halves. Both halves step on every module clock, and no carry passes from the lower half into the upper half. This lets a tester exercise every bit of the counter in a few hundred cycles rather than tens of thousands. In split mode the overflow flag responds only to the upper half wrapping.

Top module: `fr_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the count to 0x0000, the overflow flag to 0 and the prescaler to 0, and selects normal mode with a prescale select of 0. After reset the counter counts as one 16-bit value, so 256 clocks from reset give 0x0100.
- R2: In normal mode with select N (0..7), the prescaler divides the clock by 2^N. The count grows by one on every 2^N-th clock and holds on all other clocks.
- R3: In normal mode, the step from 0xFFFF to 0x0000 sets the overflow flag in the same clock edge.
- R4: In split mode the prescaler is held at zero, and bits 7:0 and bits 15:8 of the count each increase by one on every clock.
- R5: In split mode the lower half wrapping from 0xFF to 0x00 does not carry into bits 15:8.
- R6: In split mode only the upper half wrapping from 0xFF to 0x00 sets the overflow flag. A wrap of the lower half leaves the flag unchanged.
- R7: The overflow flag stays set until a clock edge where `flag_wr` is 1 and `flag_wdata` is 1, which clears it. A write with `flag_wdata` = 0 has no effect.
- R8: When an overflow and a clearing write fall on the same edge, the flag ends up set.
- R9: When `cmp_clr` is high on a clock with a prescaler tick, the count becomes 0x0000 instead of counting, and that tick raises no overflow. When `cmp_clr` is high on a clock without a tick, it has no effect.
- R10: The edge with `cfg_we` high loads `cfg_bypass` and `cfg_psel`, and the new values act from the following clock. On leaving split mode the prescaler restarts from zero, so with select 1 the first tick comes on the second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Loads the configuration register |
| cfg_bypass | input | 1 | 1 selects the split test mode, 0 selects normal mode |
| cfg_psel | input | 3 | Prescale select N; the divide ratio is 2^N |
| cmp_clr | input | 1 | Compare-match request to zero the count on the next tick |
| flag_wr | input | 1 | Write strobe for the overflow flag |
| flag_wdata | input | 1 | Write data; 1 clears the flag |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Several properties are checked on every cycle: the count holds between prescaler ticks, both halves step together in split mode with the prescaler pinned at zero, the flag is sticky and set wins over clear, the flag never rises without a wrap event, and a compare clear on a tick zeroes the count. Other behaviour can only be shown by the bench scenarios. These are the exact divide ratio for each select value, the overflow landing on the 65,536th tick, the no-carry boundary between the halves, and the prescaler phase after leaving split mode. The bench sweeps all eight select values and runs a full 16-bit wrap. It also drives clear writes and compare clears onto the exact cycles of an upper-half wrap.

// File: rtl/fr_timer_pkg.sv
package fr_timer_pkg;
    parameter int unsigned CNT_W  = 16;
    parameter int unsigned PSEL_W = 3;
    localparam int unsigned HALF_W = CNT_W / 2;
    localparam int unsigned PRE_W  = (1 << PSEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    typedef struct packed {
        logic flag;
    } flg_st_t;

    typedef struct packed {
        logic              bypass;
        logic [PSEL_W-1:0] psel;
    } cfg_st_t;
endpackage

// File: rtl/fr_timer_prescale.sv
module fr_timer_prescale
    import fr_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick,
    output logic [PRE_W-1:0]  pre_val
);
    pre_st_t          s_q, s_d;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;

    always_comb begin
        span = ((PRE_W+1)'(1) << psel) - (PRE_W+1)'(1);
        mask = span[PRE_W-1:0];
        s_d  = s_q;
        if (hold) begin
            s_d.pre = '0;
            tick    = 1'b1;
        end else begin
            s_d.pre = s_q.pre + PRE_W'(1);
            tick    = ((s_q.pre & mask) == mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pre_val = s_q.pre;
endmodule

// File: rtl/fr_timer_cnt.sv
module fr_timer_cnt
    import fr_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             split,
    input  logic             clr_req,
    output logic [CNT_W-1:0] count,
    output logic             wrap_evt
);
    cnt_st_t                s_q, s_d;
    logic [1:0][HALF_W-1:0] half_nx;
    logic [1:0]             half_top;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half_nx[h]  = s_q.cnt[h*HALF_W +: HALF_W] + HALF_W'(1);
        assign half_top[h] = &s_q.cnt[h*HALF_W +: HALF_W];
    end

    always_comb begin
        s_d      = s_q;
        wrap_evt = 1'b0;
        if (tick) begin
            if (clr_req) begin
                s_d.cnt = '0;
            end else if (split) begin
                s_d.cnt  = half_nx;
                wrap_evt = half_top[1];
            end else begin
                s_d.cnt  = s_q.cnt + CNT_W'(1);
                wrap_evt = &half_top;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign count = s_q.cnt;
endmodule

// File: rtl/fr_timer_flag.sv
module fr_timer_flag
    import fr_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_wr,
    input  logic clr_data,
    output logic flag
);
    flg_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (set_evt)                s_d.flag = 1'b1;
        else if (clr_wr && clr_data) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign flag = s_q.flag;
endmodule

// File: rtl/fr_timer.sv
module fr_timer
    import fr_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_bypass,
    input  logic [PSEL_W-1:0] cfg_psel,
    input  logic              cmp_clr,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_flag
);
    cfg_st_t          cfg_q, cfg_d;
    logic             tick;
    logic             wrap_evt;
    logic [PRE_W-1:0] pre_cnt;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.bypass = cfg_bypass;
            cfg_d.psel   = cfg_psel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    fr_timer_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .hold    (cfg_q.bypass),
        .psel    (cfg_q.psel),
        .tick    (tick),
        .pre_val (pre_cnt)
    );

    fr_timer_cnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .split    (cfg_q.bypass),
        .clr_req  (cmp_clr),
        .count    (count),
        .wrap_evt (wrap_evt)
    );

    fr_timer_flag u_flg (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (wrap_evt),
        .clr_wr   (flag_wr),
        .clr_data (flag_wdata),
        .flag     (ovf_flag)
    );
endmodule

// File: rtl/fr_timer_chk.sv
module fr_timer_chk
    import fr_timer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmp_clr,
    input logic             flag_wr,
    input logic             flag_wdata,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             tick,
    input logic             wrap_evt,
    input logic             bypass_q,
    input logic [PRE_W-1:0] pre_val
);
    // R1: reset leaves a zero count and a clear flag
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !ovf_flag));

    // R2: the count does not move between prescaler ticks
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick) |=> $stable(count));

    // R4: the prescaler is held at zero in split mode
    p_pre_held_r4: assert property (@(posedge clk) disable iff (rst)
        bypass_q |=> (pre_val == '0));

    // R5: both halves step by one, with no carry between them
    p_halves_step_r5: assert property (@(posedge clk) disable iff (rst)
        (bypass_q && !cmp_clr) |=>
        (count[HALF_W-1:0] == $past(count[HALF_W-1:0]) + HALF_W'(1)) &&
        (count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W]) + HALF_W'(1)));

    // R6: the flag rises only on a wrap event
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (!ovf_flag && !wrap_evt) |=> !ovf_flag);

    // R7: the flag stays set without a clearing write
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !(flag_wr && flag_wdata)) |=> ovf_flag);

    // R8: a wrap sets the flag even with a clearing write on the same edge
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> ovf_flag);

    // R9: a compare clear on a tick zeroes the count
    p_cmp_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && cmp_clr) |=> (count == '0));
endmodule

bind fr_timer fr_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmp_clr    (cmp_clr),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .count      (count),
    .ovf_flag   (ovf_flag),
    .tick       (tick),
    .wrap_evt   (wrap_evt),
    .bypass_q   (cfg_q.bypass),
    .pre_val    (pre_cnt)
);

// File: tb/tb_fr_timer.sv
module tb_fr_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_bypass = 1'b0;
    logic [2:0]  cfg_psel = 3'd0;
    logic        cmp_clr = 1'b0;
    logic        flag_wr = 1'b0;
    logic        flag_wdata = 1'b0;
    logic [15:0] count;
    logic        ovf_flag;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // reference state, updated from the requirements at each rising edge
    logic [15:0] m_cnt = '0;
    logic        m_flag = 1'b0;
    logic        m_byp = 1'b0;
    int unsigned m_psel = 0;
    int unsigned m_pre = 0;
    int unsigned m_div;
    logic        m_tk;
    logic        m_wrap;
    logic [15:0] m_nx;

    always #4 clk = ~clk;

    fr_timer dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_bypass (cfg_bypass),
        .cfg_psel   (cfg_psel),
        .cmp_clr    (cmp_clr),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .count      (count),
        .ovf_flag   (ovf_flag)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_flag = 1'b0; m_byp = 1'b0; m_psel = 0; m_pre = 0;
        end else begin
            m_div  = 1 << m_psel;
            m_tk   = m_byp || ((m_pre % m_div) == (m_div - 1));
            m_wrap = 1'b0;
            m_nx   = m_cnt;
            if (m_tk) begin
                if (cmp_clr) begin
                    m_nx = 16'h0000;
                end else if (m_byp) begin
                    m_nx[7:0]  = m_cnt[7:0] + 8'd1;
                    m_nx[15:8] = m_cnt[15:8] + 8'd1;
                    m_wrap     = (m_cnt[15:8] == 8'hFF);
                end else begin
                    m_nx   = m_cnt + 16'd1;
                    m_wrap = (m_cnt == 16'hFFFF);
                end
            end
            if (m_wrap)                     m_flag = 1'b1;
            else if (flag_wr && flag_wdata) m_flag = 1'b0;
            m_pre = m_byp ? 0 : (m_pre + 1) % 128;
            if (cfg_we) begin
                m_byp  = cfg_bypass;
                m_psel = cfg_psel;
            end
            m_cnt = m_nx;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_cmp++;
            if (count !== m_cnt || ovf_flag !== m_flag) begin
                n_bad++;
                $display("FAIL %s per-cycle: actual count=%h flag=%b expected count=%h flag=%b",
                         cur_tag, count, ovf_flag, m_cnt, m_flag);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic byp, input logic [2:0] ps);
        cfg_we = 1'b1; cfg_bypass = byp; cfg_psel = ps;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        cyc(2);
        chk("R1 count after reset", count, 16'h0000);
        chk("R1 flag after reset", {15'd0, ovf_flag}, 16'd0);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R2: every select value; the load edge still runs at select 0
        cur_tag = "R2";
        for (int n = 0; n < 8; n++) begin
            reset_dut();
            write_cfg(1'b0, 3'(n));
            cyc(20 << n);
            chk("R2 divided count", count, 16'd21);
            chk("R2 no flag", {15'd0, ovf_flag}, 16'd0);
        end

        // R3: full 16-bit wrap at select 0
        cur_tag = "R3";
        reset_dut();
        cyc(65535);
        chk("R3 count at top", count, 16'hFFFF);
        chk("R3 flag before wrap", {15'd0, ovf_flag}, 16'd0);
        cyc(1);
        chk("R3 count after wrap", count, 16'h0000);
        chk("R3 flag after wrap", {15'd0, ovf_flag}, 16'd1);

        // R7: write of 0 is ignored, write of 1 clears
        cur_tag = "R7";
        flag_wr = 1'b1; flag_wdata = 1'b0;
        cyc(1);
        chk("R7 zero write ignored", {15'd0, ovf_flag}, 16'd1);
        flag_wdata = 1'b1;
        cyc(1);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        chk("R7 one write clears", {15'd0, ovf_flag}, 16'd0);

        // R4/R5/R6: split mode
        cur_tag = "R4";
        reset_dut();
        write_cfg(1'b1, 3'd0);
        cyc(255);
        chk("R5 low wrap leaves high half", count, 16'hFF00);
        chk("R6 low wrap sets no flag", {15'd0, ovf_flag}, 16'd0);
        cyc(1);
        chk("R4 both halves step", count, 16'h0001);
        chk("R6 high wrap sets flag", {15'd0, ovf_flag}, 16'd1);

        cur_tag = "R8";
        flag_wr = 1'b1; flag_wdata = 1'b1;
        cyc(1);
        flag_wr = 1'b0;
        chk("R7 clear in split mode", {15'd0, ovf_flag}, 16'd0);
        cyc(254);
        chk("R8 high half at top", count, 16'hFF00);
        flag_wr = 1'b1;
        cyc(1);
        flag_wr = 1'b0;
        chk("R8 set wins over clear", {15'd0, ovf_flag}, 16'd1);
        chk("R8 count after wrap", count, 16'h0001);

        cur_tag = "R9";
        flag_wr = 1'b1;
        cyc(1);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        cyc(254);
        chk("R9 high half at top", count, 16'hFF00);
        cmp_clr = 1'b1;
        cyc(1);
        cmp_clr = 1'b0;
        chk("R9 clear on tick zeroes", count, 16'h0000);
        chk("R9 cleared tick no flag", {15'd0, ovf_flag}, 16'd0);
        cyc(1);
        chk("R4 resume both halves", count, 16'h0101);

        // R10: back to normal with select 1
        cur_tag = "R10";
        write_cfg(1'b0, 3'd1);
        chk("R10 load edge still split", count, 16'h0202);
        cyc(1);
        chk("R10 prescaler restarts, no tick", count, 16'h0202);
        cyc(1);
        chk("R10 first tick second clock", count, 16'h0203);

        // R1: reset in split mode returns to normal 16-bit counting
        cur_tag = "R1";
        write_cfg(1'b1, 3'd0);
        cyc(5);
        reset_dut();
        cyc(256);
        chk("R1 normal mode after reset", count, 16'h0100);

        // R9: compare clear off-tick has no effect, on-tick zeroes
        cur_tag = "R9";
        reset_dut();
        write_cfg(1'b0, 3'd2);
        cyc(8);
        chk("R9 count before clear", count, 16'd3);
        cmp_clr = 1'b1;
        cyc(1);
        chk("R9 off-tick clear ignored", count, 16'd3);
        cyc(2);
        cmp_clr = 1'b0;
        chk("R9 on-tick clear zeroes", count, 16'd0);
        cyc(4);

        cmp_on = 1'b0;
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule